// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtracter

This block adds or subtracts two packed single-precision values (1 sign bit, 8 exponent bits, 23 fraction bits, exponent bias 127) and returns a packed result with four status flags. A control input selects subtraction, which flips the sign of the second operand before the operation. The datapath is pipelined in two stages and accepts a new operation on every clock. A valid bit travels alongside the data so a consumer knows which output cycles carry results.

The first stage unpacks both operands, orders them by exponent, right-aligns the smaller significand while gathering guard, round and sticky bits, and performs the significand addition or subtraction. For equal exponents it forms both difference orders at once and keeps the non-negative one. The register sits right after that operation. The second stage normalizes through one of two paths: the addition path, which folds the carry-out shift and the round-to-2.0 case into one exponent increment, or the subtraction path, which counts leading zeros, shifts left and checks for underflow. Both paths round to nearest, ties to even. Subnormal values are not supported: an operand with a zero exponent field counts as zero, and no subnormal result is produced.

Top module: `fpa_addsub`

## Requirements
- R1: `out_vld` rises exactly two rising clock edges after a cycle with `in_vld` high; one operation is accepted every cycle; reset (active low, asynchronous) clears `out_vld`, `result` and all flags.
- R2: Effective addition (operand signs equal after `do_sub` is applied) returns the sum rounded to nearest, ties to even. A sum of 2.0 or more, or a rounding carry up to 2.0, raises the exponent by one.
- R3: Effective subtraction normalizes the difference by its leading-zero count. A rounding carry into 2.0 lands in the exponent field (for example, 1.0 minus 2^-25 gives exactly 1.0).
- R4: With equal exponents, the result sign is the sign of the operand with the larger magnitude, and an exact zero difference returns +0 (0x00000000).
- R5: Any NaN input (exponent 255, fraction nonzero), and infinity minus infinity, returns the quiet NaN 0x7FC00000 with `flag_nan` set and no other flag set.
- R6: An infinite operand in a valid case returns infinity (exponent 255, fraction 0) with that operand's effective sign, and sets `flag_inf`.
- R7: If the exponent passes 254 after normalization, the result is infinity of the result's sign, and both `flag_ovf` and `flag_inf` are set.
- R8: If a subtraction result needs an exponent below 1, the result is a zero of the result's sign and `flag_unf` is set. A result with exponent exactly 1 is returned normally.
- R9: An operand with exponent field 0 counts as zero. The other operand is returned, with its sign flipped if it is the subtracted operand. Two zeros give -0 only when both effective signs are negative. No output has a zero exponent and a nonzero fraction.
- R10: Bits shifted out during alignment fold into a sticky bit. A discarded part of exactly one half rounds to even. Anything above one half rounds up. An operand more than 26 exponent steps below the other has no effect under a tie-free rounding.
- R11: `do_sub` = 1 computes a minus b, and this also applies to infinities and zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands and control are valid this cycle |
| opnd_a | input | 32 | First operand, packed single precision |
| opnd_b | input | 32 | Second operand, packed single precision |
| do_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| out_vld | output | 1 | Result and flags are valid |
| result | output | 32 | Packed single-precision result |
| flag_nan | output | 1 | Result is the quiet NaN |
| flag_inf | output | 1 | Result is an infinity |
| flag_ovf | output | 1 | Exponent overflow produced the infinity |
| flag_unf | output | 1 | Exponent underflow flushed the result to zero |

## Verification
The bench targets rounding ties on both sides of the even rule, a rounding carry into 2.0 on the addition path and on the subtraction path, and full cancellation of equal operands. A design that drops the sticky bit would round 1.0 plus a value just above half an ULP down. A design that ignores the carry on the subtraction path would return half of the correct value. A design that picks the wrong difference order on equal exponents would return a wrong sign or a wrapped magnitude. Further tests cover exponent overflow, underflow at the exponent-1 boundary, the NaN cases (including infinity minus infinity), signed zeros and zero-exponent operands. Each of these shows up as a wrong word or a wrong flag at the ports. All vectors are streamed back to back, so a design that stalls or skews its latency misreports every following result.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Status bits returned alongside each result
   typedef struct packed {
      logic nan;
      logic inf;
      logic ovf;
      logic unf;
   } fpa_flags_t;

   // Round-to-nearest, ties-to-even increment decision
   function automatic logic rne_up(input logic lsb, input logic guard, input logic tail);
      return guard & (tail | lsb);
   endfunction

endpackage

// File: rtl/fpa_front.sv
// Stage 1: unpack, order by exponent, align with GRS, add or subtract significands.
module fpa_front #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 op_sub,
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   output logic                 sgn,
   output logic [EXP_W-1:0]     exp_big,
   output logic [MAN_W+4:0]     mag,
   output logic                 eff_sub,
   output logic                 spec,
   output logic [EXP_W+MAN_W:0] spec_val,
   output fpa_pkg::fpa_flags_t  spec_flg
);
   import fpa_pkg::*;

   localparam int W  = EXP_W + MAN_W + 1;
   localparam int X  = MAN_W + 4;          // hidden + fraction + guard/round/sticky
   localparam int S  = X + 1;              // one carry bit on top
   localparam int DW = $clog2(X + 1);
   localparam logic [EXP_W-1:0] EMAX = '1;

   logic             sa, sb;
   logic [EXP_W-1:0] ea, eb, e_diff;
   logic [MAN_W-1:0] ma, mb;
   logic             a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, a_first;
   logic             s_big, s_sml;
   logic [X-1:0]     big_ext, sml_ext, aligned;
   logic [DW-1:0]    d_cap;
   logic [2*X-1:0]   wide;
   logic [S-1:0]     sum, dif_fw, dif_bw;

   assign {sa, ea, ma} = a;
   assign sb = b[W-1] ^ op_sub;
   assign eb = b[W-2:MAN_W];
   assign mb = b[MAN_W-1:0];

   assign a_zero = (ea == '0);
   assign b_zero = (eb == '0);
   assign a_inf  = (ea == EMAX) && (ma == '0);
   assign b_inf  = (eb == EMAX) && (mb == '0);
   assign a_nan  = (ea == EMAX) && (ma != '0);
   assign b_nan  = (eb == EMAX) && (mb != '0);

   // Swap so the larger exponent leads
   assign a_first = (ea >= eb);
   assign exp_big = a_first ? ea : eb;
   assign e_diff  = a_first ? (ea - eb) : (eb - ea);
   assign s_big   = a_first ? sa : sb;
   assign s_sml   = a_first ? sb : sa;
   assign big_ext = {1'b1, (a_first ? ma : mb), 3'b000};
   assign sml_ext = {1'b1, (a_first ? mb : ma), 3'b000};

   // Alignment: shift right, then fold every lost bit into the sticky position
   assign d_cap   = (32'(e_diff) >= X) ? DW'(X) : DW'(e_diff);
   assign wide    = {sml_ext, {X{1'b0}}} >> d_cap;
   assign aligned = wide[2*X-1:X] | {{(X-1){1'b0}}, |wide[X-1:0]};

   // Significand operation; both difference orders formed in parallel
   assign eff_sub = sa ^ sb;
   assign sum     = {1'b0, big_ext} + {1'b0, aligned};
   assign dif_fw  = {1'b0, big_ext} - {1'b0, aligned};
   assign dif_bw  = {1'b0, aligned} - {1'b0, big_ext};

   always_comb begin
      if (!eff_sub) begin
         mag = sum;
         sgn = s_big;
      end else if (dif_fw[S-1]) begin   // only reachable with equal exponents
         mag = dif_bw;
         sgn = s_sml;
      end else begin
         mag = dif_fw;
         sgn = s_big;
      end
   end

   // Special operands bypass the arithmetic
   always_comb begin
      spec     = 1'b1;
      spec_val = '0;
      spec_flg = '0;
      if (a_nan || b_nan || (a_inf && b_inf && eff_sub)) begin
         spec_val     = {1'b0, EMAX, 1'b1, {(MAN_W-1){1'b0}}};
         spec_flg.nan = 1'b1;
      end else if (a_inf) begin
         spec_val     = {sa, EMAX, {MAN_W{1'b0}}};
         spec_flg.inf = 1'b1;
      end else if (b_inf) begin
         spec_val     = {sb, EMAX, {MAN_W{1'b0}}};
         spec_flg.inf = 1'b1;
      end else if (a_zero && b_zero) begin
         spec_val     = {sa & sb, {(W-1){1'b0}}};
      end else if (a_zero) begin
         spec_val     = {sb, eb, mb};
      end else if (b_zero) begin
         spec_val     = a;
      end else begin
         spec         = 1'b0;
      end
   end
endmodule

// File: rtl/fpa_norm_add.sv
// Stage 2, effective addition: one shared increment covers carry-out and round-to-2.0.
module fpa_norm_add #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 live,
   input  logic                 sgn,
   input  logic [EXP_W-1:0]     exp_in,
   input  logic [MAN_W+4:0]     mag,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 ovf
);
   import fpa_pkg::*;

   localparam int P = MAN_W + 1;
   localparam int X = MAN_W + 4;
   localparam int S = X + 1;
   localparam logic [EXP_W-1:0] EMAX = '1;

   logic [X-1:0]     m;
   logic [P-1:0]     keep;
   logic [P:0]       rounded;
   logic             up, carry, inc;
   logic [EXP_W+1:0] exp_n;
   logic [MAN_W-1:0] frac;

   assign m       = mag[S-1] ? {mag[S-1:2], mag[1] | mag[0]} : mag[X-1:0];
   assign keep    = m[X-1:3];
   assign up      = rne_up(keep[0], m[2], m[1] | m[0]);
   assign rounded = {1'b0, keep} + (P+1)'(up);
   assign carry   = rounded[P];
   assign inc     = mag[S-1] | carry;
   assign exp_n   = {2'b00, exp_in} + (EXP_W+2)'(inc);
   assign ovf     = (exp_n >= {2'b00, EMAX});
   assign frac    = carry ? '0 : rounded[MAN_W-1:0];
   assign res     = ovf ? {sgn, EMAX, {MAN_W{1'b0}}} : {sgn, exp_n[EXP_W-1:0], frac};

   AST_ADD_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (rounded[MAN_W] || carry)); // R2
endmodule

// File: rtl/fpa_norm_sub.sv
// Stage 2, effective subtraction: leading-zero shift, underflow check, packed rounding.
module fpa_norm_sub #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 live,
   input  logic                 sgn,
   input  logic [EXP_W-1:0]     exp_in,
   input  logic [MAN_W+3:0]     mag,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 unf
);
   import fpa_pkg::*;

   localparam int X  = MAN_W + 4;
   localparam int W  = EXP_W + MAN_W + 1;
   localparam int DW = $clog2(X + 1);

   function automatic logic [DW-1:0] lead_zeros(input logic [X-1:0] v);
      logic [DW-1:0] n;
      logic          hit;
      n   = DW'(X);
      hit = 1'b0;
      for (int i = X - 1; i >= 0; i--) begin
         if (!hit && v[i]) begin
            n   = DW'(X - 1 - i);
            hit = 1'b1;
         end
      end
      return n;
   endfunction

   logic               is_zero, up;
   logic [DW-1:0]      k;
   logic [X-1:0]       shifted;
   logic [EXP_W-1:0]   exp_n;
   logic [MAN_W:0]     keep;
   logic [W-2:0]       packed_r;

   assign is_zero  = (mag == '0);
   assign k        = lead_zeros(mag);
   assign shifted  = mag << k;
   assign unf      = !is_zero && ({{DW{1'b0}}, exp_in} <= {{EXP_W{1'b0}}, k});
   assign exp_n    = exp_in - EXP_W'(k);
   assign keep     = shifted[X-1:3];
   assign up       = rne_up(keep[0], shifted[2], |shifted[1:0]);
   // A rounding carry out of the fraction walks into the exponent field
   assign packed_r = {exp_n, keep[MAN_W-1:0]} + (W-1)'(up);
   assign res      = is_zero ? '0 : (unf ? {sgn, {(W-1){1'b0}}} : {sgn, packed_r});

   AST_SUB_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !is_zero) |-> shifted[X-1]); // R3
endmodule

// File: rtl/fpa_addsub.sv
// Two-stage floating-point adder/subtracter; register right after the significand operation.
module fpa_addsub #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [EXP_W+MAN_W:0] opnd_a,
   input  logic [EXP_W+MAN_W:0] opnd_b,
   input  logic                 do_sub,
   output logic                 out_vld,
   output logic [EXP_W+MAN_W:0] result,
   output logic                 flag_nan,
   output logic                 flag_inf,
   output logic                 flag_ovf,
   output logic                 flag_unf
);
   import fpa_pkg::*;

   localparam int W  = EXP_W + MAN_W + 1;
   localparam int X  = MAN_W + 4;
   localparam int S  = X + 1;
   localparam int DW = $clog2(X + 1);

   generate
      if (EXP_W < 3 || MAN_W < 2) begin : g_bad_fmt
         $error("fpa_addsub: format too narrow");
      end
      if (EXP_W < DW) begin : g_bad_shift
         $error("fpa_addsub: exponent cannot hold the normalization shift");
      end
   endgenerate

   // Stage 1 combinational outputs
   logic             f_sgn, f_sub, f_spec;
   logic [EXP_W-1:0] f_exp;
   logic [S-1:0]     f_mag;
   logic [W-1:0]     f_sval;
   fpa_flags_t       f_sflg;

   fpa_front #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_front (
      .op_sub(do_sub), .a(opnd_a), .b(opnd_b),
      .sgn(f_sgn), .exp_big(f_exp), .mag(f_mag), .eff_sub(f_sub),
      .spec(f_spec), .spec_val(f_sval), .spec_flg(f_sflg)
   );

   // Pipeline register after the significand operation
   logic             s1_vld, s1_sgn, s1_sub, s1_spec;
   logic [EXP_W-1:0] s1_exp;
   logic [S-1:0]     s1_mag;
   logic [W-1:0]     s1_sval;
   fpa_flags_t       s1_sflg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_sgn  <= 1'b0;
         s1_sub  <= 1'b0;
         s1_spec <= 1'b0;
         s1_exp  <= '0;
         s1_mag  <= '0;
         s1_sval <= '0;
         s1_sflg <= '0;
      end else begin
         s1_vld  <= in_vld;
         s1_sgn  <= f_sgn;
         s1_sub  <= f_sub;
         s1_spec <= f_spec;
         s1_exp  <= f_exp;
         s1_mag  <= f_mag;
         s1_sval <= f_sval;
         s1_sflg <= f_sflg;
      end
   end

   // Stage 2: two normalization paths
   logic [W-1:0] add_res, sub_res, nxt_res;
   logic         add_ovf, sub_unf;
   fpa_flags_t   nxt_flg;

   fpa_norm_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nadd (
      .clk(clk), .rst_n(rst_n), .live(s1_vld && !s1_sub && !s1_spec),
      .sgn(s1_sgn), .exp_in(s1_exp), .mag(s1_mag), .res(add_res), .ovf(add_ovf)
   );

   fpa_norm_sub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nsub (
      .clk(clk), .rst_n(rst_n), .live(s1_vld && s1_sub && !s1_spec),
      .sgn(s1_sgn), .exp_in(s1_exp), .mag(s1_mag[X-1:0]), .res(sub_res), .unf(sub_unf)
   );

   always_comb begin
      nxt_flg = '0;
      if (s1_spec) begin
         nxt_res = s1_sval;
         nxt_flg = s1_sflg;
      end else if (!s1_sub) begin
         nxt_res     = add_res;
         nxt_flg.ovf = add_ovf;
         nxt_flg.inf = add_ovf;
      end else begin
         nxt_res     = sub_res;
         nxt_flg.unf = sub_unf;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         result   <= '0;
         flag_nan <= 1'b0;
         flag_inf <= 1'b0;
         flag_ovf <= 1'b0;
         flag_unf <= 1'b0;
      end else begin
         out_vld  <= s1_vld;
         result   <= nxt_res;
         flag_nan <= nxt_flg.nan;
         flag_inf <= nxt_flg.inf;
         flag_ovf <= nxt_flg.ovf;
         flag_unf <= nxt_flg.unf;
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld, 2)); // R1
   AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && flag_nan) |-> (result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}})); // R5
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $onehot0({flag_nan, flag_inf, flag_unf})); // R5
   AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && flag_ovf) |-> (flag_inf && result[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}})); // R7
   AST_UNF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && flag_unf) |-> (result[W-2:0] == '0)); // R8
   AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((result[W-2:MAN_W] != '0) || (result[MAN_W-1:0] == '0))); // R9
endmodule

// File: tb/tb_fpa_addsub.sv
module tb_fpa_addsub;

   logic        clk = 1'b0;
   logic        rst_n, in_vld, do_sub;
   logic [31:0] opnd_a, opnd_b, result;
   logic        out_vld, flag_nan, flag_inf, flag_ovf, flag_unf;

   always #5 clk = ~clk;

   fpa_addsub dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .do_sub(do_sub), .out_vld(out_vld), .result(result),
      .flag_nan(flag_nan), .flag_inf(flag_inf), .flag_ovf(flag_ovf), .flag_unf(flag_unf)
   );

   // flg = {nan, inf, ovf, unf}
   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic        sub;
      logic [31:0] res;
      logic [3:0]  flg;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VEC [NV] = '{
      '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'b0000, 8'd2},  // R2 1+1
      '{32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 4'b0000, 8'd2},  // R2 1.5+2.5
      '{32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 4'b0000, 8'd2},  // R2 round carry to 2.0
      '{32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 4'b0000, 8'd2},  // R2 tie, odd lsb
      '{32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'b0000, 8'd10}, // R10 tie, even lsb
      '{32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 4'b0000, 8'd10}, // R10 sticky above half
      '{32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000, 4'b0000, 8'd10}, // R10 far operand
      '{32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 4'b0000, 8'd11}, // R11 3-1
      '{32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 4'b0000, 8'd3},  // R3 deep cancel
      '{32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, 4'b0000, 8'd3},  // R3 carry into exp
      '{32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'b0000, 8'd4},  // R4 exact zero
      '{32'h3F800000, 32'h3FC00000, 1'b1, 32'hBF000000, 4'b0000, 8'd4},  // R4 b larger
      '{32'hBFC00000, 32'h3F800000, 1'b0, 32'hBF000000, 4'b0000, 8'd4},  // R4 mixed signs
      '{32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 4'b0000, 8'd4},  // R4 -1+1 = +0
      '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'b0110, 8'd7},  // R7 +overflow
      '{32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 4'b0110, 8'd7},  // R7 -overflow
      '{32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 4'b0001, 8'd8},  // R8 underflow
      '{32'h01000000, 32'h00800000, 1'b1, 32'h00800000, 4'b0000, 8'd8},  // R8 exponent 1 kept
      '{32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b1000, 8'd5},  // R5 NaN in a
      '{32'h3F800000, 32'h7F800001, 1'b1, 32'h7FC00000, 4'b1000, 8'd5},  // R5 NaN in b
      '{32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 4'b1000, 8'd5},  // R5 inf-inf
      '{32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 4'b0100, 8'd6},  // R6 inf+inf
      '{32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, 4'b0100, 8'd6},  // R6 -inf+1
      '{32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 4'b0100, 8'd11}, // R11 1-inf
      '{32'h00000000, 32'h3F800000, 1'b0, 32'h3F800000, 4'b0000, 8'd9},  // R9 0+1
      '{32'h00000000, 32'h40000000, 1'b1, 32'hC0000000, 4'b0000, 8'd9},  // R9 0-2
      '{32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000, 4'b0000, 8'd9},  // R9 zero-exp operand
      '{32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 4'b0000, 8'd9}   // R9 -0 - +0
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input int req, input int idx, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d item %0d: got %h expected %h", req, idx, act, exp);
      end
   endtask

   initial begin
      rst_n  = 1'b0;
      in_vld = 1'b0;
      do_sub = 1'b0;
      opnd_a = '0;
      opnd_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(1, -1, {31'd0, out_vld}, 32'd0);
      chk(1, -1, result, 32'd0);
      chk(1, -1, {28'd0, flag_nan, flag_inf, flag_ovf, flag_unf}, 32'd0);

      // Streamed table, one operation per cycle; results appear two edges later
      for (int i = 0; i < NV + 2; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            chk(1, i - 2, {31'd0, out_vld}, 32'd1);                         // R1
            chk(VEC[i-2].req, i - 2, result, VEC[i-2].res);
            chk(VEC[i-2].req, i - 2, {28'd0, flag_nan, flag_inf, flag_ovf, flag_unf},
                {28'd0, VEC[i-2].flg});
         end
         if (i < NV) begin
            opnd_a = VEC[i].a;
            opnd_b = VEC[i].b;
            do_sub = VEC[i].sub;
            in_vld = 1'b1;
         end else begin
            in_vld = 1'b0;
         end
      end

      // R1 bubble: idle input yields idle output
      @(negedge clk);
      chk(1, 100, {31'd0, out_vld}, 32'd0);

      // R1 reset in flight drops the pending result
      opnd_a = 32'h3F800000;
      opnd_b = 32'h3F800000;
      do_sub = 1'b0;
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      chk(1, 101, {31'd0, out_vld}, 32'd0);
      chk(1, 101, result, 32'd0);
      rst_n = 1'b1;

      // R2 single operation after reset, checked at the exact latency
      opnd_a = 32'h40000000;
      opnd_b = 32'h40000000;
      in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      chk(1, 102, {31'd0, out_vld}, 32'd0);
      @(negedge clk);
      chk(1, 102, {31'd0, out_vld}, 32'd1);
      chk(2, 102, result, 32'h40800000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: got 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule